// File: doc/BRIEF.md
# Line clock jitter smoother

This block takes a serial bit stream that arrives with a noisy clock, about 1.544 Mbit/s, and sends it back out on a clean clock of the same average rate. Each received bit goes into a 32-entry, one-bit-wide elastic store. A clock that is about 64.77 times the line rate runs the whole block. The output clock comes from that fast clock through a divider that picks either 64 or 65 cycles for each period. The choice depends on the carry out of a phase accumulator.

The block counts writes. After every 32 writes it captures the fill of the store, which is the write pointer minus the read pointer, taken modulo 32. That captured fill sets a signed trim on the accumulator step. A fill below 14 makes the output slower. A fill above 15 makes it faster. A fill of 14 or 15 leaves the nominal step unchanged.

The line clock and line data are sampled through two-flop synchronizers and a rising-edge detector. The line side has no back-pressure: every line edge is one accepted bit. The output side has no ready signal: each output period delivers one bit.

Top module: `jitter_smoother`

## Requirements
- R1: While rst_n is low, smooth_clk and smooth_data are 0. The read pointer is preset 15 entries behind the write pointer, so the first 15 output bits are 0 and the first line bit follows them.
- R2: Each rising edge of line_clk, seen after two synchronizer flops, writes the line_data value present at that edge into the store. Every bit written comes out exactly once.
- R3: Bits leave the store in the order they were written. Each output bit appears on smooth_data at the rising edge of smooth_clk, and neither the store nor its output underflows or overflows while the line rate stays inside the trim range.
- R4: Every smooth_clk period lasts either 64 or 65 clk cycles. smooth_clk is high for the first 32 cycles of each period.
- R5: A period lasts 65 cycles exactly when the previous period's step added into the 16-bit accumulator produced a carry. With no trim, the step is NOM_STEP (50254), which gives an average of about 64.767 clk cycles per period.
- R6: The fill (write pointer minus read pointer, modulo 32) is captured on every 32nd write. Between captures the held value does not change.
- R7: A held fill f below 14 adds min(14-f,3)*4096 to the step, which lengthens the periods. A fill above 15 subtracts min(f-15,3)*4096, which shortens them. A fill of 14 or 15 adds nothing.
- R8: In closed loop, the average smooth_clk period follows the line clock. It is longer than nominal when the line is slow and shorter than nominal when the line is fast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock, nominally 64.77 times the line rate |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| line_clk | input | 1 | Jittery line clock, asynchronous |
| line_data | input | 1 | Line data, valid at rising edges of line_clk |
| smooth_clk | output | 1 | Cleaned output clock |
| smooth_data | output | 1 | Data re-timed to smooth_clk |

## Verification
Two pairs of events can land in the same clk cycle. A line write can coincide with an output read; both pointers then move together and the fill must stay unchanged. The fill capture on the 32nd write can also coincide with a read. Random edge jitter of about ±12 ns on line_clk slides the line phase across the output period, so both pairs occur many times during a run. A scoreboard judges the result by matching every output bit against the queued line bits. Period widths and windowed average periods at slow, nominal and fast line rates are also checked.

// File: rtl/jsm_pkg.sv
package jsm_pkg;
  localparam int PTR_W       = 5;   // store pointer width, depth is 2**PTR_W
  localparam int ACC_W       = 16;  // phase accumulator width
  localparam int SYNC_STAGES = 2;   // synchronizer depth for line inputs
endpackage

// File: rtl/jsm_line_sync.sv
module jsm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_clk,
  input  logic line_data,
  output logic wr_stb,
  output logic wr_bit
);
  logic [STAGES-1:0] clk_sh;
  logic [STAGES-1:0] dat_sh;
  logic              clk_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sh   <= '0;
      dat_sh   <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sh   <= {clk_sh[STAGES-2:0], line_clk};
      dat_sh   <= {dat_sh[STAGES-2:0], line_data};
      clk_prev <= clk_sh[STAGES-1];
    end
  end

  assign wr_stb = clk_sh[STAGES-1] & ~clk_prev;
  assign wr_bit = dat_sh[STAGES-1];

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R2
endmodule

// File: rtl/jsm_elastic_store.sv
module jsm_elastic_store #(
  parameter int PTR_W     = 5,
  parameter int FILL_INIT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             wr_bit,
  input  logic             rd_stb,
  output logic             rd_bit,
  output logic [PTR_W-1:0] fill
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DEPTH-1:0] mem;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem    <= '0;
      wr_ptr <= '0;
      rd_ptr <= PTR_W'(DEPTH - FILL_INIT);
      rd_bit <= 1'b0;
    end else begin
      if (wr_stb) begin
        mem[wr_ptr] <= wr_bit;
        wr_ptr      <= wr_ptr + 1'b1;
      end
      if (rd_stb) begin
        rd_bit <= mem[rd_ptr];
        rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end

  assign fill = wr_ptr - rd_ptr;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> fill != '0); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !rd_stb) |-> fill != PTR_W'(DEPTH - 1)); // R3
  AST_FILL_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && rd_stb) |=> $stable(fill)); // R3
endmodule

// File: rtl/jsm_fill_monitor.sv
module jsm_fill_monitor #(
  parameter int PTR_W     = 5,
  parameter int ACC_W     = 16,
  parameter int SAMPLE_W  = 5,
  parameter int FILL_LO   = 14,
  parameter int FILL_HI   = 15,
  parameter int FILL_INIT = 15,
  parameter int TRIM_LSB  = 4096,
  parameter int TRIM_MAX  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_stb,
  input  logic [PTR_W-1:0]        fill,
  output logic signed [ACC_W:0]   trim
);
  localparam int TRIM_W = ACC_W + 1;

  logic [SAMPLE_W-1:0] wr_cnt;
  logic [PTR_W-1:0]    held;
  logic                latch_en;
  int                  units;

  assign latch_en = wr_stb && (wr_cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt <= '0;
      held   <= PTR_W'(FILL_INIT);
    end else begin
      if (wr_stb)   wr_cnt <= wr_cnt + 1'b1;
      if (latch_en) held   <= fill;
    end
  end

  // computed lookup: held fill -> signed step correction
  always_comb begin
    units = 0;
    if (int'(held) < FILL_LO) begin
      units = FILL_LO - int'(held);
      if (units > TRIM_MAX) units = TRIM_MAX;
    end else if (int'(held) > FILL_HI) begin
      units = int'(held) - FILL_HI;
      if (units > TRIM_MAX) units = TRIM_MAX;
      units = -units;
    end
    trim = TRIM_W'(units * TRIM_LSB);
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> $stable(held)); // R6
  AST_TRIM_SLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && fill < PTR_W'(FILL_LO)) |=> trim > 0); // R7
  AST_TRIM_SPEEDS: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && fill > PTR_W'(FILL_HI)) |=> trim < 0); // R7
endmodule

// File: rtl/jsm_frac_divider.sv
module jsm_frac_divider #(
  parameter int ACC_W    = 16,
  parameter int DIV_BASE = 64,
  parameter int NOM_STEP = 50254
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic signed [ACC_W:0] trim,
  output logic                  tick,
  output logic                  out_clk
);
  localparam int CNT_W = $clog2(DIV_BASE + 1);
  localparam int HALF  = DIV_BASE / 2;
  localparam logic [ACC_W-1:0] NOM_V = ACC_W'(NOM_STEP);

  logic [CNT_W-1:0]        cnt;
  logic [CNT_W-1:0]        end_cnt;
  logic                    long_q;
  logic [ACC_W-1:0]        acc;
  logic signed [ACC_W+1:0] step_s;
  logic [ACC_W-1:0]        step;
  logic [ACC_W:0]          acc_sum;

  assign step_s  = $signed({2'b00, NOM_V}) + $signed({trim[ACC_W], trim});
  assign step    = step_s[ACC_W-1:0];
  assign acc_sum = {1'b0, acc} + {1'b0, step};
  assign end_cnt = long_q ? CNT_W'(DIV_BASE) : CNT_W'(DIV_BASE - 1);
  assign tick    = (cnt == end_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      long_q  <= 1'b0;
      acc     <= '0;
      out_clk <= 1'b0;
    end else if (tick) begin
      cnt     <= '0;
      acc     <= acc_sum[ACC_W-1:0];
      long_q  <= acc_sum[ACC_W];
      out_clk <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(HALF - 1)) out_clk <= 1'b0;
    end
  end

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> out_clk); // R4
  AST_HIGH_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_clk) |-> cnt == CNT_W'(HALF)); // R4
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step_s[ACC_W+1:ACC_W] == 2'b00); // R5
endmodule

// File: rtl/jitter_smoother.sv
module jitter_smoother
  import jsm_pkg::*;
#(
  parameter int DIV_BASE  = 64,
  parameter int NOM_STEP  = 50254,
  parameter int TRIM_LSB  = 4096,
  parameter int TRIM_MAX  = 3,
  parameter int FILL_LO   = 14,
  parameter int FILL_HI   = 15,
  parameter int FILL_INIT = 15,
  parameter int SAMPLE_W  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_clk,
  input  logic line_data,
  output logic smooth_clk,
  output logic smooth_data
);
  logic                  wr_stb;
  logic                  wr_bit;
  logic                  rd_stb;
  logic [PTR_W-1:0]      fill;
  logic signed [ACC_W:0] trim;

  jsm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .line_data(line_data),
    .wr_stb(wr_stb), .wr_bit(wr_bit)
  );

  jsm_elastic_store #(.PTR_W(PTR_W), .FILL_INIT(FILL_INIT)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_bit(wr_bit),
    .rd_stb(rd_stb), .rd_bit(smooth_data), .fill(fill)
  );

  jsm_fill_monitor #(
    .PTR_W(PTR_W), .ACC_W(ACC_W), .SAMPLE_W(SAMPLE_W),
    .FILL_LO(FILL_LO), .FILL_HI(FILL_HI), .FILL_INIT(FILL_INIT),
    .TRIM_LSB(TRIM_LSB), .TRIM_MAX(TRIM_MAX)
  ) u_mon (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .fill(fill), .trim(trim)
  );

  jsm_frac_divider #(.ACC_W(ACC_W), .DIV_BASE(DIV_BASE), .NOM_STEP(NOM_STEP)) u_div (
    .clk(clk), .rst_n(rst_n), .trim(trim), .tick(rd_stb), .out_clk(smooth_clk)
  );
endmodule

// File: tb/jitter_smoother_test.sv
`timescale 1ns/1ps
module jitter_smoother_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_clk = 1'b0;
  logic line_data = 1'b0;
  logic smooth_clk;
  logic smooth_data;

  int  checks = 0;
  int  failures = 0;
  int  data_checks = 0;
  int  nrise = 0;
  real last_rise = 0.0;
  real ideal = 0.0;
  bit  done = 1'b0;
  bit  exp_q[$];

  always #2 clk = ~clk; // 250 MHz

  jitter_smoother uut (
    .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .line_data(line_data),
    .smooth_clk(smooth_clk), .smooth_data(smooth_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // driver: one jittered line period per bit, expected bit pushed at the edge
  task automatic drive_line(input int nper, input real tper);
    for (int i = 0; i < nper; i++) begin
      real jit;
      real tgt;
      jit = real'($urandom_range(0, 24)) - 12.0;
      tgt = ideal + jit;
      if (tgt > $realtime) #(tgt - $realtime);
      line_clk = 1'b1;
      exp_q.push_back(line_data);
      #(tper / 2.0);
      line_clk = 1'b0;
      line_data = 1'($urandom_range(0, 1));
      ideal += tper;
    end
  endtask

  // monitor: period widths (R4) and scoreboard order (R2, R3)
  always @(posedge smooth_clk) begin
    real tnow;
    real per;
    bit  expb;
    tnow = $realtime;
    if (nrise > 0) begin
      per = tnow - last_rise;
      chk(((per > 255.9) && (per < 256.1)) || ((per > 259.9) && (per < 260.1)),
          "R4", "period ns", per, 258.0);
    end
    last_rise = tnow;
    nrise++;
    #1;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R3", "output bit with empty scoreboard", real'(smooth_data), -1.0);
    end else begin
      expb = exp_q.pop_front();
      data_checks++;
      chk(smooth_data == expb, "R3", "smooth_data order", real'(smooth_data), real'(expb));
    end
  end

  initial begin
    int  n0, n1;
    real t0, t1, avg;
    repeat (5) @(posedge clk);
    #1;
    chk(smooth_clk == 1'b0, "R1", "smooth_clk in reset", real'(smooth_clk), 0.0);
    chk(smooth_data == 1'b0, "R1", "smooth_data in reset", real'(smooth_data), 0.0);
    repeat (5) @(posedge clk);
    #1;
    chk(smooth_clk == 1'b0, "R1", "smooth_clk held in reset", real'(smooth_clk), 0.0);
    // R1: fifteen preset zero bits precede the first line bit
    for (int k = 0; k < 15; k++) exp_q.push_back(1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    ideal = $realtime + 50.0;

    // nominal rate: R5 average of dithered 64/65 periods
    drive_line(60, 259.07);
    n0 = nrise; t0 = last_rise;
    drive_line(140, 259.07);
    n1 = nrise; t1 = last_rise;
    avg = (t1 - t0) / real'(n1 - n0);
    chk((avg > 258.9) && (avg < 259.25), "R5", "nominal average period", avg, 259.07);

    // slow line: fill drains, R6 captures, R7 lengthens periods, R8 tracks
    drive_line(700, 259.7);
    n0 = nrise; t0 = last_rise;
    drive_line(300, 259.7);
    n1 = nrise; t1 = last_rise;
    avg = (t1 - t0) / real'(n1 - n0);
    chk(avg > 259.15, "R7", "slow-line average period", avg, 259.4);
    chk(avg > 259.15, "R8", "output follows slow line", avg, 259.4);
    chk(avg > 259.15, "R6", "captured fill drives slow trim", avg, 259.4);

    // fast line: fill grows, R7 shortens periods, R8 tracks
    drive_line(900, 258.4);
    n0 = nrise; t0 = last_rise;
    drive_line(300, 258.4);
    n1 = nrise; t1 = last_rise;
    avg = (t1 - t0) / real'(n1 - n0);
    chk(avg < 258.95, "R7", "fast-line average period", avg, 258.7);
    chk(avg < 258.95, "R8", "output follows fast line", avg, 258.7);

    chk(data_checks > 2000, "R2", "line bits delivered", real'(data_checks), 2000.0);
    chk(exp_q.size() < 32, "R2", "bits still in flight", real'(exp_q.size()), 16.0);
    finish_up();
  end

  initial begin
    #760000;
    checks++;
    failures++;
    $display("FAIL watchdog R3 run did not finish actual=%0d expected=%0d", nrise, 2400);
    finish_up();
  end
endmodule